// File: doc/BRIEF.md
# Radix-2 Delay-Feedback FFT Stage

This block is a single stage of a pipelined decimation-in-frequency FFT. It takes one complex sample per clock on a valid-qualified stream and produces one complex sample per valid input once it is primed. The stage holds a feedback delay of `DLY = N_PTS / 2^(STAGE+1)` complex samples, one radix-2 butterfly and one twiddle multiplier. Chaining `log2(N_PTS)` copies with `STAGE` set to 0, 1, 2 and so on yields a streaming transform whose result comes out in bit-reversed order.

A modulo-`2*DLY` position counter advances on each valid input and splits the period into two halves. In the first half, incoming samples are parked in the delay line. The value that leaves the delay line is the scaled difference left there in the previous period, and it is sent out after a twiddle rotation. In the second half, the butterfly pairs each parked sample with the new input. It sends out half their sum at once and parks half their difference for rotation in the next period. Each butterfly output is halved, so the growth per stage is bounded.

Top module: `sdf_fft_stage`

## Requirements
- R1: While `rst_ni` is low and in the cycle after it is released, `out_valid_o` is 0.
- R2: An output produced from the valid input sampled at clock edge t appears on the ports after edge t+2, which is three cycles of latency.
- R3: After reset, the first `DLY` valid inputs produce no output. The first output belongs to the valid input at position `DLY`, counting from 0.
- R4: For valid input j in the second half of a period (position p with `DLY <= p < 2*DLY`), the output is `(a + x) >>> 1` per component. Here `a` is the input at position `p-DLY` of the same period, `x` is the current input, and the shift is an arithmetic shift, so the result rounds toward minus infinity.
- R5: For a valid input at position `k < DLY` of any period after the first, the output is the rotated stored difference. The stored difference is `d = (a - x) >>> 1`, kept from position `DLY+k` of the previous period. Rotation gives re = `(d.re*c - d.im*s) >>> 15` and im = `(d.re*s + d.im*c) >>> 15`. The coefficients are `c = round(32767*cos(2*pi*e/N_PTS))` and `s = -round(32767*sin(2*pi*e/N_PTS))`, with rounding half away from zero.
- R6: The position counter advances only on cycles with `in_valid_i` high. Idle cycles between samples do not change any output value.
- R7: A rotated component outside the signed 16-bit range saturates to 32767 or -32768.
- R8: Asserting `rst_ni` in the middle of a stream restarts the period at position 0 and discards samples still in flight. The next `DLY` valid inputs again produce no output.
- R9: Once primed, every valid input produces exactly one output, and `out_valid_o` is never high without a matching input.
- R10: The twiddle exponent is `e = k * 2^STAGE`. For example, with `N_PTS=16` and `STAGE=2`, k=1 uses the coefficient pair (0, -32767).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample qualifier |
| in_re_i | input | 16 | Input real part, signed Q1.15 |
| in_im_i | input | 16 | Input imaginary part, signed Q1.15 |
| out_valid_o | output | 1 | Output sample qualifier |
| out_re_o | output | 16 | Output real part, signed Q1.15 |
| out_im_o | output | 16 | Output imaginary part, signed Q1.15 |

## Verification
A counter that slips by one position, for example through a count on an idle cycle, swaps the butterfly and pass-through halves. It also mispairs delay-line entries, so the output values go wrong on the very next valid sample. A fault in the delay line or on the feedback path shows up only one half-period later, when the stored difference comes back through the rotator. For that reason every output in both halves is compared, including with gaps in the stream. A wrong twiddle index or exponent appears only in the first-half outputs. It is caught by running the stage at two stage numbers and by a saturating case at a 45-degree twiddle.

// File: rtl/sdf_fft_pkg.sv
package sdf_fft_pkg;

  localparam int unsigned SMP_W = 16;

  typedef logic signed [SMP_W-1:0] smp_t;

  typedef struct packed {
    smp_t re;
    smp_t im;
  } cplx_t;

  // floor((a+b)/2) without loss
  function automatic smp_t half_add(smp_t a, smp_t b);
    logic signed [SMP_W:0] t;
    t = {a[SMP_W-1], a} + {b[SMP_W-1], b};
    return t[SMP_W:1];
  endfunction

  function automatic smp_t half_sub(smp_t a, smp_t b);
    logic signed [SMP_W:0] t;
    t = {a[SMP_W-1], a} - {b[SMP_W-1], b};
    return t[SMP_W:1];
  endfunction

  // Coefficient of exp(-j*2*pi*num/den), scaled by 2^(w-1)-1
  function automatic int tw_q(int num, int den, bit neg_sin, int unsigned w);
    real ang;
    real v;
    ang = 6.283185307179586 * real'(num) / real'(den);
    v = neg_sin ? -$sin(ang) : $cos(ang);
    v = v * real'((1 << (w - 1)) - 1);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/sdf_delay_line.sv
module sdf_delay_line
  import sdf_fft_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  shift_i,
  input  cplx_t din_i,
  output cplx_t dout_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    cplx_t q;
    cplx_t nxt;
    if (i == 0) begin : g_head
      assign nxt = din_i;
    end else begin : g_body
      assign nxt = g_tap[i-1].q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (shift_i) q <= nxt;
    end
  end

  assign dout_o = g_tap[DEPTH-1].q;

endmodule

// File: rtl/sdf_butterfly.sv
module sdf_butterfly
  import sdf_fft_pkg::*;
(
  input  logic  phase_i,
  input  cplx_t fb_i,
  input  cplx_t in_i,
  output cplx_t fwd_o,
  output cplx_t fb_o
);

  cplx_t sum;
  cplx_t dif;

  always_comb begin
    sum.re = half_add(fb_i.re, in_i.re);
    sum.im = half_add(fb_i.im, in_i.im);
    dif.re = half_sub(fb_i.re, in_i.re);
    dif.im = half_sub(fb_i.im, in_i.im);
    if (phase_i) begin
      fwd_o = sum;
      fb_o  = dif;
    end else begin
      fwd_o = fb_i;   // previous period's difference leaves for rotation
      fb_o  = in_i;   // park new sample
    end
  end

endmodule

// File: rtl/sdf_twiddle_rom.sv
module sdf_twiddle_rom
  import sdf_fft_pkg::*;
#(
  parameter int unsigned N_PTS = 16,
  parameter int unsigned STAGE = 0,
  parameter int unsigned TW_W  = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0]       idx_i,
  output logic signed [TW_W-1:0] w_re_o,
  output logic signed [TW_W-1:0] w_im_o
);

  logic signed [TW_W-1:0] cos_tab [DEPTH];
  logic signed [TW_W-1:0] sin_tab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam int CV = tw_q(k * (1 << STAGE), N_PTS, 1'b0, TW_W);
    localparam int SV = tw_q(k * (1 << STAGE), N_PTS, 1'b1, TW_W);
    assign cos_tab[k] = TW_W'(CV);
    assign sin_tab[k] = TW_W'(SV);
  end

  assign w_re_o = cos_tab[idx_i];
  assign w_im_o = sin_tab[idx_i];

endmodule

// File: rtl/sdf_cmult.sv
module sdf_cmult
  import sdf_fft_pkg::*;
#(
  parameter int unsigned TW_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   use_tw_i,
  input  cplx_t                  data_i,
  input  logic signed [TW_W-1:0] w_re_i,
  input  logic signed [TW_W-1:0] w_im_i,
  output logic                   valid_o,
  output cplx_t                  data_o
);

  localparam int unsigned PR_W = SMP_W + TW_W;
  localparam int unsigned SM_W = PR_W + 1;
  localparam int unsigned FR_W = TW_W - 1;

  logic signed [PR_W-1:0] rr_q, ii_q, ri_q, ir_q;
  cplx_t byp_q;
  logic  tw_q;
  logic  vld_q;

  function automatic smp_t narrow(logic signed [SM_W-1:0] v);
    logic signed [SM_W-1:0]  s;
    logic [SM_W-SMP_W:0]     hi;
    s  = v >>> FR_W;
    hi = s[SM_W-1:SMP_W-1];
    if (&hi || ~|hi) return s[SMP_W-1:0];
    return s[SM_W-1] ? {1'b1, {(SMP_W-1){1'b0}}} : {1'b0, {(SMP_W-1){1'b1}}};
  endfunction

  // products registered apart from the final add/shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tw_q  <= 1'b0;
      byp_q <= '0;
      rr_q  <= '0;
      ii_q  <= '0;
      ri_q  <= '0;
      ir_q  <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        tw_q  <= use_tw_i;
        byp_q <= data_i;
        rr_q  <= PR_W'(data_i.re) * PR_W'(w_re_i);
        ii_q  <= PR_W'(data_i.im) * PR_W'(w_im_i);
        ri_q  <= PR_W'(data_i.re) * PR_W'(w_im_i);
        ir_q  <= PR_W'(data_i.im) * PR_W'(w_re_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= vld_q;
      if (vld_q) begin
        if (tw_q) begin
          data_o.re <= narrow(SM_W'(rr_q) - SM_W'(ii_q));
          data_o.im <= narrow(SM_W'(ri_q) + SM_W'(ir_q));
        end else begin
          data_o <= byp_q;
        end
      end
    end
  end

endmodule

// File: rtl/sdf_fft_stage.sv
module sdf_fft_stage
  import sdf_fft_pkg::*;
#(
  parameter int unsigned N_PTS = 16,
  parameter int unsigned STAGE = 0,
  parameter int unsigned TW_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [SMP_W-1:0] in_re_i,
  input  logic [SMP_W-1:0] in_im_i,
  output logic             out_valid_o,
  output logic [SMP_W-1:0] out_re_o,
  output logic [SMP_W-1:0] out_im_o
);

  localparam int unsigned DLY   = N_PTS >> (STAGE + 1);
  localparam int unsigned CNT_W = $clog2(2 * DLY);
  localparam int unsigned IDX_W = (DLY > 1) ? $clog2(DLY) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;
  logic             phase;
  logic [IDX_W-1:0] tw_idx;

  cplx_t din, head, fwd, push;

  assign phase   = cnt_q[CNT_W-1];
  assign din.re  = in_re_i;
  assign din.im  = in_im_i;

  if (DLY > 1) begin : g_idx
    assign tw_idx = cnt_q[IDX_W-1:0];
  end else begin : g_idx_one
    assign tw_idx = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (in_valid_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (phase) primed_q <= 1'b1;
    end
  end

  sdf_delay_line #(
    .DEPTH (DLY)
  ) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (in_valid_i),
    .din_i   (push),
    .dout_o  (head)
  );

  sdf_butterfly u_bfly (
    .phase_i (phase),
    .fb_i    (head),
    .in_i    (din),
    .fwd_o   (fwd),
    .fb_o    (push)
  );

  logic             s1_valid_q;
  logic             s1_tw_q;
  logic [IDX_W-1:0] s1_idx_q;
  cplx_t            s1_data_q;

  // first half of the very first period carries only reset contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_tw_q    <= 1'b0;
      s1_idx_q   <= '0;
      s1_data_q  <= '0;
    end else begin
      s1_valid_q <= in_valid_i & (primed_q | phase);
      if (in_valid_i) begin
        s1_tw_q   <= ~phase;
        s1_idx_q  <= tw_idx;
        s1_data_q <= fwd;
      end
    end
  end

  logic signed [TW_W-1:0] w_re, w_im;

  sdf_twiddle_rom #(
    .N_PTS (N_PTS),
    .STAGE (STAGE),
    .TW_W  (TW_W),
    .DEPTH (DLY),
    .IDX_W (IDX_W)
  ) u_rom (
    .idx_i  (s1_idx_q),
    .w_re_o (w_re),
    .w_im_o (w_im)
  );

  cplx_t res;

  sdf_cmult #(
    .TW_W (TW_W)
  ) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid_q),
    .use_tw_i (s1_tw_q),
    .data_i   (s1_data_q),
    .w_re_i   (w_re),
    .w_im_i   (w_im),
    .valid_o  (out_valid_o),
    .data_o   (res)
  );

  assign out_re_o = res.re;
  assign out_im_o = res.im;

endmodule

// File: rtl/sdf_fft_stage_chk.sv
module sdf_fft_stage_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             primed_i,
  input logic             phase_i
);

  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(cnt_i));

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  // R3
  no_early_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_i |-> !out_valid_o);

  // R8
  primed_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_i |=> primed_i);

  // R2
  out_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 3));

  // R9
  out_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (primed_i || phase_i)) |-> ##3 out_valid_o);

endmodule

bind sdf_fft_stage sdf_fft_stage_chk #(
  .CNT_W (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .cnt_i       (cnt_q),
  .primed_i    (primed_q),
  .phase_i     (phase)
);

// File: tb/tb_sdf_fft_stage.sv
module tb_sdf_fft_stage;

  localparam int CLK_PERIOD = 10;
  localparam int NP  = 16;
  localparam int DL0 = 8;
  localparam int ST0 = 0;
  localparam int DL1 = 2;
  localparam int ST1 = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_re = '0;
  logic signed [15:0] in_im = '0;
  logic ov0, ov1;
  logic signed [15:0] or0, oi0, or1, oi1;

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  sdf_fft_stage #(.N_PTS(NP), .STAGE(ST0), .TW_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .in_re_i(in_re), .in_im_i(in_im),
    .out_valid_o(ov0), .out_re_o(or0), .out_im_o(oi0)
  );

  sdf_fft_stage #(.N_PTS(NP), .STAGE(ST1), .TW_W(16)) dut_s2 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .in_re_i(in_re), .in_im_i(in_im),
    .out_valid_o(ov1), .out_re_o(or1), .out_im_o(oi1)
  );

  typedef struct {
    int re;
    int im;
    int cyc;
    int req;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int   m_re [2][8];
  int   m_im [2][8];
  int   m_cnt [2];
  bit   m_pr [2];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;
  string sect = "R9";
  int unsigned seed = 32'h1234_5678;

  function automatic string rname(int r);
    case (r)
      4:  return "R4";
      5:  return "R5";
      7:  return "R7";
      10: return "R10";
      default: return "R9";
    endcase
  endfunction

  function automatic int rnd16();
    seed = seed * 1664525 + 1013904223;
    return int'($signed(seed[31:16]));
  endfunction

  function automatic int half(int a, int b, bit dif);
    int t;
    t = dif ? a - b : a + b;
    return t >>> 1;
  endfunction

  function automatic int twq(int e, bit sin_part);
    real a, v;
    a = 2.0 * 3.141592653589793 * real'(e) / real'(NP);
    v = sin_part ? -32767.0 * $sin(a) : 32767.0 * $cos(a);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  function automatic int satq(longint v, output bit hit);
    longint s;
    s = v >>> 15;
    hit = 1'b0;
    if (s > 32767)  begin hit = 1'b1; return 32767;  end
    if (s < -32768) begin hit = 1'b1; return -32768; end
    return int'(s);
  endfunction

  function automatic void model_step(int u, int xr, int xi, int c);
    int d, s, k, wr, wi;
    bit h1, h2;
    exp_t e;
    d = (u == 0) ? DL0 : DL1;
    s = (u == 0) ? ST0 : ST1;
    k = m_cnt[u] % d;
    e.cyc = c + 3;  // R2: three register stages
    if (m_cnt[u] >= d) begin
      e.re = half(m_re[u][k], xr, 1'b0);   // R4
      e.im = half(m_im[u][k], xi, 1'b0);
      e.req = 4;
      m_re[u][k] = half(m_re[u][k], xr, 1'b1);
      m_im[u][k] = half(m_im[u][k], xi, 1'b1);
      m_pr[u] = 1'b1;
      if (u == 0) q0.push_back(e); else q1.push_back(e);
    end else begin
      if (m_pr[u]) begin
        wr = twq(k << s, 1'b0);          // R10: exponent k*2^stage
        wi = twq(k << s, 1'b1);
        e.re = satq(longint'(m_re[u][k]) * wr - longint'(m_im[u][k]) * wi, h1);
        e.im = satq(longint'(m_re[u][k]) * wi + longint'(m_im[u][k]) * wr, h2);
        e.req = (h1 || h2) ? 7 : ((u == 1) ? 10 : 5);
        if (u == 0) q0.push_back(e); else q1.push_back(e);
      end
      m_re[u][k] = xr;
      m_im[u][k] = xi;
    end
    m_cnt[u] = (m_cnt[u] + 1) % (2 * d);
  endfunction

  function automatic void model_clear();
    for (int u = 0; u < 2; u++) begin
      m_cnt[u] = 0;
      m_pr[u]  = 1'b0;
      for (int k = 0; k < 8; k++) begin
        m_re[u][k] = 0;
        m_im[u][k] = 0;
      end
    end
    q0.delete();
    q1.delete();
  endfunction

  function automatic void check_unit(int u, logic v, int r, int i);
    exp_t e;
    bit   empty;
    if (!v) return;
    n_cmp++;
    empty = (u == 0) ? (q0.size() == 0) : (q1.size() == 0);
    if (empty) begin
      n_bad++;
      $display("FAIL %s R3 unit%0d: unexpected output (%0d,%0d) at cycle %0d, expected none",
               sect, u, r, i, cyc);
      return;
    end
    e = (u == 0) ? q0.pop_front() : q1.pop_front();
    if (e.cyc != cyc) begin
      n_bad++;
      $display("FAIL %s R2 unit%0d: output at cycle %0d, expected cycle %0d", sect, u, cyc, e.cyc);
    end else if (e.re != r || e.im != i) begin
      n_bad++;
      $display("FAIL %s %s unit%0d: got (%0d,%0d) expected (%0d,%0d)",
               sect, rname(e.req), u, r, i, e.re, e.im);
    end
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      check_unit(0, ov0, int'(or0), int'(oi0));
      check_unit(1, ov1, int'(or1), int'(oi1));
    end
  end

  task automatic drive(bit v, int xr, int xi);
    @(negedge clk);
    in_valid = v;
    in_re = 16'(xr);
    in_im = 16'(xi);
    if (v) begin
      model_step(0, xr, xi, cyc);
      model_step(1, xr, xi, cyc);
    end
  endtask

  task automatic check_idle(string tag);
    n_cmp++;
    if (ov0 !== 1'b0 || ov1 !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: out_valid got (%b,%b) expected (0,0)", tag, ov0, ov1);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    model_clear();
    repeat (2) @(negedge clk);
    check_idle("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    // R3/R4/R5/R7: extremes at k=2, then an impulse period
    sect = "R9";
    for (int j = 0; j < 16; j++) begin
      if (j == 2)       drive(1'b1, 32767, 32767);
      else if (j == 10) drive(1'b1, -32768, -32768);
      else              drive(1'b1, j * 1500 - 9000, 7000 - j * 900);
    end
    for (int j = 0; j < 16; j++) drive(1'b1, (j == 0) ? 16384 : 0, 0);
    for (int j = 0; j < 32; j++) drive(1'b1, rnd16(), rnd16());

    // R6: gaps in the stream
    sect = "R6";
    for (int j = 0; j < 96; j++) drive(seed[20], rnd16(), rnd16());

    // R8: reset mid-period
    sect = "R8";
    for (int j = 0; j < 5; j++) drive(1'b1, rnd16(), rnd16());
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_clear();
    @(negedge clk);
    check_idle("R8 in reset");
    rst_n = 1'b1;
    for (int j = 0; j < 40; j++) drive(1'b1, rnd16(), rnd16());
    for (int j = 0; j < 8; j++) drive(1'b0, 0, 0);

    // R9: every expected output was delivered
    n_cmp++;
    if (q0.size() != 0 || q1.size() != 0) begin
      n_bad++;
      $display("FAIL R9: pending outputs got (%0d,%0d) expected (0,0)", q0.size(), q1.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: run got hung, expected completion");
      summary();
      $finish;
    end
  end

endmodule